// File: doc/BRIEF.md
# Sticky Alarm Interrupt Status Register

This block turns a set of live receiver alarm levels into latched status bits and a single interrupt line. The seven alarms are reference clock loss, loss of signal, loss of lock, receive FIFO error, test-pattern error alarm, test-pattern sync loss and signal quality alarm. Each one sets its own sticky bit, and that bit stays set after the alarm goes away. Software reads the whole register at a single address. It clears individual bits by writing a zero to their positions. Writing a one to a position has no effect.

A per-bit mask and a global interrupt enable come in from elsewhere. The interrupt output is the registered OR of every sticky bit whose mask bit is 1, gated by the global enable. Turning the global enable off empties the whole register. The alarm inputs are taken as already synchronous to `clk`.

Top module: `alarm_latch_reg`

## Requirements
- R1: After reset `rd_data` is 0x00 and `irq_o` is 0.
- R2: Bit 7 of `rd_data` always reads 0, and a write to bit 7 changes nothing.
- R3: `alarm_in[i]` drives sticky bit i. The order from bit 6 down to bit 0 is: reference clock loss, loss of signal, loss of lock, FIFO error, pattern error alarm, pattern sync loss, signal quality alarm.
- R4: While `irq_en`=1, an alarm input that is high at a clock edge sets its bit. The bit reads 1 from that edge on and stays 1 until it is cleared.
- R5: A write (`wr_en`=1) with a 0 in bit position i clears sticky bit i at the next edge.
- R6: A write with a 1 in bit position i leaves sticky bit i unchanged, so software cannot set a bit.
- R7: When an alarm is high in the same cycle as a write of 0 to its bit, the bit is 1 after the edge.
- R8: While `irq_en`=0, every sticky bit is 0 after each edge, whatever the alarms and writes are.
- R9: After each edge, `irq_o` equals `irq_en` AND (OR over i of sticky[i] AND `irq_mask[i]`), using the values present before that edge. A mask bit of 1 enables that bit.
- R10: `rd_data` is the current sticky value, and reading it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alarm_in | input | 7 | Live alarm levels, already synchronous to `clk` |
| irq_mask | input | 7 | Per-bit interrupt enable mask; 1 lets the bit through |
| irq_en | input | 1 | Global interrupt enable; 0 clears every sticky bit |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | 8 | Write data; a 0 in a position clears that bit |
| rd_data | output | 8 | Status read value, bit 7 always 0 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench uses the default of seven alarms. This keeps the state small enough to sweep every combination directly. It drives every alarm pattern (128 values), every write byte (256 values) against a full register, and every mask value against a varied sticky pattern. This covers each write-0 clear, each write-1 keep, reserved bit 7, and every way the mask can gate the interrupt. Dedicated sequences cover alarm-over-clear collisions for each bit, clearing on enable drop, and idle reads.

// File: rtl/alarm_latch_reg.sv
module alarm_latch_reg #(
  parameter int NUM_ALARMS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] alarm_in,
  input  logic [NUM_ALARMS-1:0] irq_mask,
  input  logic                  irq_en,
  input  logic                  wr_en,
  input  logic [NUM_ALARMS:0]   wr_data,
  output logic [NUM_ALARMS:0]   rd_data,
  output logic                  irq_o
);
  localparam int RegW = NUM_ALARMS + 1;

  logic [NUM_ALARMS-1:0] sticky_q;
  logic [NUM_ALARMS-1:0] clr_vec;
  logic [NUM_ALARMS-1:0] sticky_d;

  assign clr_vec  = wr_en ? ~wr_data[NUM_ALARMS-1:0] : '0;
  assign sticky_d = irq_en ? ((sticky_q & ~clr_vec) | alarm_in) : '0;
  assign rd_data  = {1'b0, sticky_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      irq_o    <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      irq_o    <= irq_en & (|(sticky_q & irq_mask));
    end
  end

  logic unused_w;
  assign unused_w = wr_data[RegW-1];
endmodule

module alarm_latch_reg_chk #(
  parameter int NUM_ALARMS = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_ALARMS-1:0] alarm_in,
  input logic [NUM_ALARMS-1:0] irq_mask,
  input logic                  irq_en,
  input logic                  wr_en,
  input logic [NUM_ALARMS:0]   wr_data,
  input logic [NUM_ALARMS:0]   rd_data,
  input logic                  irq_o
);
  p_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[NUM_ALARMS] == 1'b0);

  p_alarm_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && alarm_in != '0) |=>
      ((rd_data[NUM_ALARMS-1:0] & $past(alarm_in)) == $past(alarm_in)));

  p_write0_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && wr_en && alarm_in == '0) |=>
      ((rd_data[NUM_ALARMS-1:0] & ~$past(wr_data[NUM_ALARMS-1:0])) == '0));

  p_no_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_in == '0) |=>
      ((rd_data[NUM_ALARMS-1:0] & ~$past(rd_data[NUM_ALARMS-1:0])) == '0));

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> (rd_data == '0));

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(irq_en && ((rd_data[NUM_ALARMS-1:0] & irq_mask) != '0))));
endmodule

bind alarm_latch_reg alarm_latch_reg_chk #(.NUM_ALARMS(NUM_ALARMS)) chk_i (
  .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .irq_mask(irq_mask),
  .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .irq_o(irq_o)
);

// File: tb/alarm_latch_reg_tb.sv
module alarm_latch_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] alarm_in = '0;
  logic [6:0] irq_mask = '0;
  logic       irq_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;
  logic [6:0] m_sticky = '0;
  logic       m_irq = 1'b0;

  always #5 clk = ~clk;

  alarm_latch_reg dut_i (
    .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .irq_mask(irq_mask),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [7:0] exp_rd, input logic exp_irq);
    checks++;
    if (rd_data !== exp_rd || irq_o !== exp_irq) begin
      errors++;
      $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b", tag, rd_data, irq_o, exp_rd, exp_irq);
    end
  endtask

  task automatic step(input string tag, input logic [6:0] a, input logic [6:0] m,
                      input logic en, input logic we, input logic [7:0] wd);
    logic [6:0] clr;
    alarm_in = a; irq_mask = m; irq_en = en; wr_en = we; wr_data = wd;
    @(posedge clk);
    m_irq = en & (|(m_sticky & m));
    clr = we ? ~wd[6:0] : 7'h00;
    m_sticky = en ? ((m_sticky & ~clr) | a) : 7'h00;
    #1;
    check(tag, {1'b0, m_sticky}, m_irq);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: rd=%h irq=%b expected completion", rd_data, irq_o);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 8'h00, 1'b0);
    rst_n = 1'b1;

    step("R1", 7'h00, 7'h7F, 1'b1, 1'b0, 8'h00);

    for (int i = 0; i < 7; i++) begin
      step("R3", 7'(1 << i), 7'h00, 1'b1, 1'b0, 8'h00);
      if (rd_data !== 8'(1 << i)) begin
        errors++;
        $display("FAIL R3: rd=%h expected %h", rd_data, 8'(1 << i));
      end
      checks++;
      step("R4", 7'h00, 7'h00, 1'b1, 1'b0, 8'h00);
      step("R6", 7'h00, 7'h00, 1'b1, 1'b1, 8'hFF);
      step("R5", 7'h00, 7'h00, 1'b1, 1'b1, ~8'(1 << i));
    end

    for (int p = 0; p < 128; p++) begin
      step("R4", 7'(p), 7'h7F, 1'b1, 1'b0, 8'h00);
      step("R4", 7'h00, 7'h7F, 1'b1, 1'b0, 8'h00);
      step("R5", 7'h00, 7'h7F, 1'b1, 1'b1, 8'h00);
    end

    for (int d = 0; d < 256; d++) begin
      step("R6", 7'h7F, 7'h00, 1'b1, 1'b0, 8'h00);
      step("R5", 7'h00, 7'h00, 1'b1, 1'b1, 8'(d));
      step("R2", 7'h00, 7'h00, 1'b1, 1'b1, 8'h80);
    end

    for (int i = 0; i < 7; i++) begin
      step("R7", 7'(1 << i), 7'h00, 1'b1, 1'b0, 8'h00);
      step("R7", 7'(1 << i), 7'h00, 1'b1, 1'b1, 8'h00);
      step("R5", 7'h00, 7'h00, 1'b1, 1'b1, 8'h00);
    end

    step("R8", 7'h7F, 7'h7F, 1'b1, 1'b0, 8'h00);
    step("R8", 7'h00, 7'h7F, 1'b0, 1'b0, 8'h00);
    step("R8", 7'h7F, 7'h7F, 1'b0, 1'b1, 8'hFF);
    step("R8", 7'h55, 7'h7F, 1'b0, 1'b0, 8'h00);

    for (int m = 0; m < 128; m++) begin
      step("R9", 7'((m * 5 + 3) & 7'h7F), 7'(m), 1'b1, 1'b0, 8'h00);
      step("R9", 7'h00, 7'(m), 1'b1, 1'b0, 8'h00);
      step("R9", 7'h00, 7'(m), 1'b1, 1'b1, 8'h00);
    end
    step("R9", 7'h7F, 7'h7F, 1'b1, 1'b0, 8'h00);
    step("R9", 7'h00, 7'h7F, 1'b0, 1'b0, 8'h00);

    step("R10", 7'h2A, 7'h00, 1'b1, 1'b0, 8'h00);
    for (int k = 0; k < 4; k++) step("R10", 7'h00, 7'h00, 1'b1, 1'b0, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule